// File: doc/BRIEF.md
# Buffered Serial Receiver with Stale-Data Interrupt

This block receives asynchronous serial characters in the 8 data bit, no parity, 1 stop bit format. A 16x oversampling tick comes from an external rate generator. The block checks the start bit at mid-bit, samples each data bit at its centre, and queues each finished character, with a framing-error flag, in a 16-entry receive queue. Software or a bus agent drains the queue through a read strobe. The queue head is always visible on the read port, and a valid flag tells whether data is waiting.

The interrupt is built to keep interrupt traffic low. It does not fire for every character. It fires only when the queue is full, or when data has sat unread for 64 bit times. A second timeout source catches a lone keystroke that would otherwise wait in the queue. The block also controls the flow of incoming data. When a new start bit is accepted while the queue is full, the request-to-send output drops, and it rises again as soon as a read frees an entry. A character that completes while the queue is full is discarded and sets a sticky overrun flag, which only an explicit clear command resets.

Top module: `srx_queue_top`

## Requirements
- R1: A frame is a low start bit, 8 data bits sent least significant bit first, and a stop bit. Each frame with a high stop bit appears on `rd_data_o` with `rd_ferr_o` = 0, and characters leave the queue in the order they arrived.
- R2: The queue holds up to 16 characters. `rd_valid_o` is 1 exactly when at least one is held, and each `rd_i` pulse while `rd_valid_o` is 1 removes the head.
- R3: `irq_o` is 1 while the queue holds 16 characters.
- R4: With the queue non-empty and not full, `irq_o` rises once 64 bit times (1024 oversampling ticks) pass with no read and no new character. A read restarts the wait and drops `irq_o` within two clock cycles. No timeout interrupt is raised while the queue is empty.
- R5: `rts_o` (1 = sender may transmit) goes to 0 when a start bit is accepted while the queue is full. It returns to 1 once a read leaves a free entry.
- R6: A character that completes while the queue is full is discarded and sets `ovr_o`. `ovr_o` then stays 1 until an `ovr_clr_i` pulse.
- R7: A stop bit sampled low still queues the character, with `rd_ferr_o` = 1. The receiver then waits for the line to return high before it looks for the next start bit.
- R8: A low pulse shorter than half a bit time is rejected as noise and queues nothing.
- R9: After reset, `rts_o` = 1, `rd_valid_o` = 0, `irq_o` = 0 and `ovr_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd_i | input | 1 | Serial receive line, idle high |
| rts_o | output | 1 | Request to send, 1 = sender may transmit |
| rd_i | input | 1 | Read strobe, pops the queue head |
| rd_data_o | output | 8 | Character at the queue head |
| rd_ferr_o | output | 1 | Framing-error flag of the queue head |
| rd_valid_o | output | 1 | Queue holds at least one character |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Receive interrupt (queue full or stale data) |

## Verification
The hardest state to reach from the ports is a start bit that arrives while the queue is already full. Only in that state do flow control, overrun and the full interrupt all act at once. The bench gets there by stopping its reading monitor and sending sixteen queued characters and then a seventeenth. It then checks that `rts_o` has dropped and `ovr_o` is set. Next it frees one entry and clears the overrun, and it drains the rest against the scoreboard to show that the discarded character never entered the queue. The stale timeout needs a long idle stretch after a single character, so the bench checks `irq_o` just before and just after the 1024-tick mark.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // Oversampling tick at which the start bit is checked (half a bit in).
  function automatic int mid_index(input int os_rate);
    return (os_rate / 2) - 1;
  endfunction

  // Number of oversampling ticks in the stale-data window.
  function automatic int stale_ticks(input int bit_times, input int os_rate);
    return bit_times * os_rate;
  endfunction

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int OS_RATE   = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick_i,
  input  logic                 rxd_i,
  output logic                 start_ok_o,
  output logic                 char_done_o,
  output logic [DATA_BITS-1:0] char_data_o,
  output logic                 char_ferr_o
);
  import srx_pkg::*;

  localparam int CW = $clog2(OS_RATE);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] MID_C  = CW'(mid_index(OS_RATE));
  localparam logic [CW-1:0] LAST_C = CW'(OS_RATE - 1);
  localparam logic [BW-1:0] NBIT_C = BW'(DATA_BITS - 1);

  logic [1:0]           sync_q;
  logic                 line;
  rx_state_e            state_q;
  logic [CW-1:0]        tick_cnt_q;
  logic [BW-1:0]        bit_idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 done_q, ferr_q, start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd_i};
  end
  assign line = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      shift_q    <= '0;
      done_q     <= 1'b0;
      ferr_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      start_q <= 1'b0;
      case (state_q)
        RX_IDLE: if (os_tick_i && !line) begin
          tick_cnt_q <= '0;
          state_q    <= RX_START;
        end
        RX_START: if (os_tick_i) begin
          if (tick_cnt_q == MID_C) begin
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
            if (!line) begin
              state_q <= RX_DATA;
              start_q <= 1'b1;
            end else begin
              state_q <= RX_IDLE;
            end
          end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
          end
        end
        RX_DATA: if (os_tick_i) begin
          if (tick_cnt_q == LAST_C) begin
            tick_cnt_q <= '0;
            shift_q    <= {line, shift_q[DATA_BITS-1:1]};
            bit_idx_q  <= bit_idx_q + 1'b1;
            if (bit_idx_q == NBIT_C) state_q <= RX_STOP;
          end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
          end
        end
        RX_STOP: if (os_tick_i) begin
          if (tick_cnt_q == LAST_C) begin
            tick_cnt_q <= '0;
            done_q     <= 1'b1;
            ferr_q     <= !line;
            state_q    <= line ? RX_IDLE : RX_HOLD;
          end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
          end
        end
        RX_HOLD: if (line) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign start_ok_o  = start_q;
  assign char_done_o = done_q;
  assign char_data_o = shift_q;
  assign char_ferr_o = ferr_q;

  // R1: a finished character is reported for exactly one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    char_done_o |=> !char_done_o);
  // R8: an accepted start bit and a finished character never coincide
  p_start_not_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok_o && char_done_o));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             push_fire_o,
  output logic             pop_fire_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [AW:0]      count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign empty_o     = (count_q == '0);
  assign full_o      = (count_q == DEPTH_C);
  assign push_fire_o = push_i && !full_o;
  assign pop_fire_o  = pop_i && !empty_o;
  assign head_o      = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push_fire_o) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_fire_o) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_fire_o)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_fire_o, pop_fire_o})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R2: occupancy never exceeds the queue depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DEPTH_C);
  // R2: a pop on a single-entry queue with no push leaves it empty
  p_pop_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire_o && !push_fire_o && count_q == 1) |=> empty_o);
endmodule

// File: rtl/srx_stale_timer.sv
module srx_stale_timer #(
  parameter int OS_RATE   = 16,
  parameter int STALE_BIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick_i,
  input  logic restart_i,
  input  logic idle_i,
  output logic stale_o
);
  import srx_pkg::*;

  localparam int LIMIT = stale_ticks(STALE_BIT, OS_RATE);
  localparam int TW    = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIMIT_C = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (restart_i || idle_i)     cnt_q <= '0;
    else if (os_tick_i && cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
  end

  assign stale_o = (cnt_q == LIMIT_C);

  // R4: the window counter is held at zero while the queue is empty
  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (cnt_q == '0));
endmodule

// File: rtl/srx_queue_top.sv
module srx_queue_top #(
  parameter int OS_RATE   = 16,
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 16,
  parameter int STALE_BIT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick_i,
  input  logic                 rxd_i,
  output logic                 rts_o,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 rd_ferr_o,
  output logic                 rd_valid_o,
  input  logic                 ovr_clr_i,
  output logic                 ovr_o,
  output logic                 irq_o
);
  localparam int EW = DATA_BITS + 1;

  // Internal events, named for the assertions
  logic                 ev_start, ev_done, ev_ferr, ev_push, ev_pop, ev_stale;
  logic [DATA_BITS-1:0] char_data;
  logic [EW-1:0]        head;
  logic                 q_empty, q_full, ev_drop;
  logic                 rts_q, ovr_q, irq_q;

  srx_deser #(.OS_RATE(OS_RATE), .DATA_BITS(DATA_BITS)) u_deser (
    .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick_i), .rxd_i(rxd_i),
    .start_ok_o(ev_start), .char_done_o(ev_done),
    .char_data_o(char_data), .char_ferr_o(ev_ferr)
  );

  srx_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(ev_done), .push_data_i({ev_ferr, char_data}),
    .pop_i(rd_i), .head_o(head),
    .empty_o(q_empty), .full_o(q_full),
    .push_fire_o(ev_push), .pop_fire_o(ev_pop)
  );

  srx_stale_timer #(.OS_RATE(OS_RATE), .STALE_BIT(STALE_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick_i),
    .restart_i(ev_push || ev_pop), .idle_i(q_empty), .stale_o(ev_stale)
  );

  assign ev_drop = ev_done && q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q <= 1'b1;
      ovr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ev_start && q_full) rts_q <= 1'b0;
      else if (!q_full)       rts_q <= 1'b1;
      if (ev_drop)            ovr_q <= 1'b1;
      else if (ovr_clr_i)     ovr_q <= 1'b0;
      irq_q <= q_full || ev_stale;
    end
  end

  assign rts_o      = rts_q;
  assign ovr_o      = ovr_q;
  assign irq_o      = irq_q;
  assign rd_data_o  = head[DATA_BITS-1:0];
  assign rd_ferr_o  = head[DATA_BITS];
  assign rd_valid_o = !q_empty;

  // R5: a start bit accepted on a full queue drops request-to-send
  p_rts_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && q_full) |=> !rts_o);
  // R6: overrun stays set until a clear pulse
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
  // R6: a dropped character never enters the queue
  p_drop_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> !ev_push);
  // R4: a stale report only exists while data is held
  p_stale_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stale |-> !q_empty);
  // R3: a full queue is signalled on the next cycle
  p_irq_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |=> irq_o);
endmodule

// File: tb/tb_srx_queue_top.sv
module tb_srx_queue_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int STALE_CLKS = 64 * BIT_CLKS;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic rd = 1'b0, ovr_clr = 1'b0, mon_en = 1'b0;
  logic rts, ferr, valid, ovr, irq;
  logic [7:0] data;
  logic [8:0] exp_q[$];
  int checks = 0, bad = 0, cycles = 0;

  srx_queue_top dut (
    .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick), .rxd_i(rxd),
    .rts_o(rts), .rd_i(rd), .rd_data_o(data), .rd_ferr_o(ferr),
    .rd_valid_o(valid), .ovr_clr_i(ovr_clr), .ovr_o(ovr), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    os_tick <= ((cycles % TICK_DIV) == TICK_DIV - 1);
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: serialise one frame; queue the expectation when it should be kept
  task automatic send_char(input logic [7:0] d, input logic stop, input logic keep);
    if (keep) exp_q.push_back({~stop, d});
    rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // Pop the head and compare with the scoreboard
  task automatic read_one(input string tag);
    logic [8:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected data"}, {ferr, data}, 0);
    end else begin
      e = exp_q.pop_front();
      chk({ferr, data} == e, tag, {ferr, data}, e);
    end
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // Monitor: drains the queue while enabled
  initial forever begin
    @(negedge clk);
    if (mon_en && valid) read_one("R1 scoreboard");
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cycles, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(rts == 1'b1, "R9 rts", rts, 1);
    chk(valid == 1'b0, "R9 valid", valid, 0);
    chk(irq == 1'b0, "R9 irq", irq, 0);
    chk(ovr == 1'b0, "R9 ovr", ovr, 0);

    // R1 several patterns through the scoreboard
    mon_en = 1'b1;
    send_char(8'hA5, 1'b1, 1'b1);
    send_char(8'h3C, 1'b1, 1'b1);
    send_char(8'h00, 1'b1, 1'b1);
    send_char(8'hFF, 1'b1, 1'b1);
    send_char(8'h81, 1'b1, 1'b1);
    // R7 low stop bit keeps the character with the error flag
    send_char(8'h5A, 1'b0, 1'b1);
    send_char(8'h12, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all received", exp_q.size(), 0);
    mon_en = 1'b0;

    // R8 short low glitch is ignored
    rxd = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk(valid == 1'b0, "R8 glitch queued nothing", valid, 0);

    // R4 stale timeout
    send_char(8'h77, 1'b1, 1'b1);
    chk(irq == 1'b0, "R4 no irq on one char", irq, 0);
    repeat (STALE_CLKS - 200) @(negedge clk);
    chk(irq == 1'b0, "R4 before window", irq, 0);
    repeat (400) @(negedge clk);
    chk(irq == 1'b1, "R4 after window", irq, 1);
    read_one("R4 stale char");
    @(negedge clk);
    chk(irq == 1'b0, "R4 read clears irq", irq, 0);
    repeat (STALE_CLKS + 400) @(negedge clk);
    chk(irq == 1'b0, "R4 empty no irq", irq, 0);

    // R3 fill the queue
    for (int i = 0; i < 16; i++) send_char(8'(8'h40 + i * 3), 1'b1, 1'b1);
    chk(irq == 1'b1, "R3 full irq", irq, 1);
    chk(rts == 1'b1, "R5 rts before extra start", rts, 1);
    chk(ovr == 1'b0, "R6 no overrun yet", ovr, 0);
    // R5 / R6 one more character while full
    send_char(8'hEE, 1'b1, 1'b0);
    chk(rts == 1'b0, "R5 rts dropped", rts, 0);
    chk(ovr == 1'b1, "R6 overrun set", ovr, 1);
    repeat (50) @(negedge clk);
    chk(ovr == 1'b1, "R6 overrun sticky", ovr, 1);
    read_one("R2 first after full");
    @(negedge clk);
    chk(rts == 1'b1, "R5 rts restored", rts, 1);
    chk(ovr == 1'b1, "R6 read does not clear", ovr, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    @(negedge clk);
    chk(ovr == 1'b0, "R6 overrun cleared", ovr, 0);
    // R2 drain the remainder in order; dropped char must not appear
    mon_en = 1'b1;
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    chk(valid == 1'b0, "R2 empty after drain", valid, 0);
    mon_en = 1'b0;

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule